// File: doc/BRIEF.md
# Power Mode and Clock Enable Controller

This block decides when a small processor subsystem runs, naps or sleeps deeply, and it turns one fast reference clock into per-domain clock-enable pulses. Software asks for one of two sleep states with a one-cycle request.

In the light sleep state (halt), the oscillator keeps running. The processor enable stops, and each peripheral can be chosen to stop or keep ticking. Any interrupt wakes the block at once.

In the deep sleep state (standby), the oscillator enable drops and every enable stops. Only an external interrupt can wake the block. After such a wake, the block holds all enables low for a programmable settling count before it returns to run.

The processor rate is chosen from six power-of-two divisions of the reference. A new rate takes effect only when the current divided period ends. Peripherals have their own divider and a per-peripheral enable mask. The block reports the present mode and the cause of the last wake.

Top module: `pmc_top`

## Requirements
- R1: While in standby, `osc_en` is 0 and `cpu_clk_en` and every bit of `per_clk_en` are 0. Both dividers restart from a count of zero when the oscillator runs again.
- R2: In standby, internal interrupts are ignored: `mode` stays 2 however long `irq_int` is high, and only a nonzero `irq_ext` leaves standby.
- R3: The value of `stab_load` is captured when standby is entered. An external wake gives exactly `stab_load`+1 cycles of `mode` = 3 with all clock enables 0, then run. Changes to `stab_load` after entry have no effect.
- R4: In halt, `osc_en` stays 1 and `cpu_clk_en` is 0. `per_clk_en[i]` is forced to 0 when `halt_gate[i]` is 1 and keeps pulsing otherwise.
- R5: In halt, any nonzero `irq_int` or `irq_ext` returns `mode` to 0 on the next clock, with no settling wait.
- R6: `freq_sel` = k (0..5) makes `cpu_clk_en` pulse once every 2^k reference cycles in run. Values 6 and 7 act as 5.
- R7: A change of `freq_sel` takes effect only after the pulse that ends the current divided period, so no shortened period appears.
- R8: `pdiv_sel` = k (0..3) makes peripheral pulses arrive once every 2^k cycles, independently of the processor rate. `per_en[i]` = 0 keeps `per_clk_en[i]` at 0.
- R9: `mode` encodes run=0, halt=1, standby=2, settling=3; reset gives 0. `wake_cause` encodes none=0, internal=1, external=2, is set on each wake with external taking priority when both are present, and otherwise holds.
- R10: A sleep request (`sleep_req`=1, `sleep_stby`=0 halt, 1 standby) moves `mode` on the next clock. A halt request is refused while any interrupt is pending, and a standby request is refused while an external interrupt is pending; when refused, `mode` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_stby | input | 1 | Request kind: 0 halt, 1 standby |
| freq_sel | input | 3 | Processor divider selection |
| pdiv_sel | input | 2 | Peripheral divider selection |
| per_en | input | 4 | Per-peripheral enable mask |
| halt_gate | input | 4 | Peripherals stopped during halt |
| stab_load | input | 12 | Settling count, captured at standby entry |
| irq_int | input | 4 | Internal interrupt lines |
| irq_ext | input | 2 | External interrupt lines |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Processor clock-enable pulse |
| per_clk_en | output | 4 | Peripheral clock-enable pulses |
| mode | output | 2 | Current mode code |
| wake_cause | output | 2 | Cause of the last wake |

## Verification
Cycle-level assertions guard several properties:
- standby is not left on internal interrupts;
- the settling state is held while its count is nonzero;
- halt ends on the clock after an interrupt;
- refused requests leave the block in run;
- divider counts stay within the selected period, and the selected rate holds mid-period;
- no enable pulses while the oscillator is off.

The bench's scenarios and its per-cycle reference model are needed for the properties that span many cycles. These are the exact pulse spacing for every rate, including the clamped codes; the absence of a short period after a rate change; the settling length set by the value captured at entry rather than a later one; and the cause priority when both interrupt kinds arrive together.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_HALT = 2'd1,
    M_STBY = 2'd2,
    M_STAB = 2'd3
  } pmc_mode_e;

  typedef enum logic [1:0] {
    C_NONE = 2'd0,
    C_INT  = 2'd1,
    C_EXT  = 2'd2
  } pmc_cause_e;
endpackage

// File: rtl/pmc_div.sv
module pmc_div #(
  parameter int NSTEP = 6,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] sel_in,
  output logic          tick
);
  localparam int CW = NSTEP;
  localparam logic [SW-1:0] SEL_MAX = SW'(NSTEP - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [SW-1:0] sel_q, sel_d, sel_ok;

  // clamp only when the select field can encode more than NSTEP settings
  generate
    if ((1 << SW) > NSTEP) begin : g_clamp
      assign sel_ok = (sel_in > SEL_MAX) ? SEL_MAX : sel_in;
    end else begin : g_pass
      assign sel_ok = sel_in;
    end
  endgenerate

  assign lim  = (CW'(1) << sel_q) - CW'(1);
  assign tick = run && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (!run) begin
      cnt_d = '0;
      sel_d = sel_ok;
    end else if (tick) begin
      cnt_d = '0;
      sel_d = sel_ok;        // rate switches only at a period boundary
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  p_cnt_in_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
  p_sel_holds_midperiod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sel_q));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int STW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleep_req,
  input  logic           sleep_stby,
  input  logic [STW-1:0] stab_load,
  input  logic           int_any,
  input  logic           ext_any,
  output pmc_mode_e      mode_o,
  output pmc_cause_e     cause_o
);
  pmc_mode_e      mode_q, mode_d;
  pmc_cause_e     cause_q, cause_d;
  logic [STW-1:0] lat_q, lat_d, scnt_q, scnt_d;

  always_comb begin
    mode_d  = mode_q;
    cause_d = cause_q;
    lat_d   = lat_q;
    scnt_d  = scnt_q;
    unique case (mode_q)
      M_RUN: begin
        if (sleep_req) begin
          if (!sleep_stby) begin
            if (!(int_any || ext_any)) mode_d = M_HALT;
          end else if (!ext_any) begin
            mode_d = M_STBY;
            lat_d  = stab_load;
          end
        end
      end
      M_HALT: begin
        if (int_any || ext_any) begin
          mode_d  = M_RUN;
          cause_d = ext_any ? C_EXT : C_INT;
        end
      end
      M_STBY: begin
        if (ext_any) begin
          mode_d  = M_STAB;
          scnt_d  = lat_q;
          cause_d = C_EXT;
        end
      end
      M_STAB: begin
        if (scnt_q == '0) mode_d = M_RUN;
        else              scnt_d = scnt_q - 1'b1;
      end
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_RUN;
      cause_q <= C_NONE;
      lat_q   <= '0;
      scnt_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      cause_q <= cause_d;
      lat_q   <= lat_d;
      scnt_q  <= scnt_d;
    end
  end

  assign mode_o  = mode_q;
  assign cause_o = cause_q;

  p_int_ignored_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STBY && !ext_any) |=> (mode_q == M_STBY));
  p_settle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STAB && scnt_q != '0) |=> (mode_q == M_STAB));
  p_halt_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALT && (int_any || ext_any)) |=> (mode_q == M_RUN));
  p_refuse_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && sleep_req && !sleep_stby && (int_any || ext_any)) |=> (mode_q == M_RUN));
  p_refuse_stby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && sleep_req && sleep_stby && ext_any) |=> (mode_q == M_RUN));
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int NPER      = 4,
  parameter int NINT      = 4,
  parameter int NEXT      = 2,
  parameter int STW       = 12,
  parameter int CPU_STEPS = 6,
  parameter int PER_STEPS = 4,
  parameter int CSW       = $clog2(CPU_STEPS),
  parameter int PSW       = $clog2(PER_STEPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            sleep_stby,
  input  logic [CSW-1:0]  freq_sel,
  input  logic [PSW-1:0]  pdiv_sel,
  input  logic [NPER-1:0] per_en,
  input  logic [NPER-1:0] halt_gate,
  input  logic [STW-1:0]  stab_load,
  input  logic [NINT-1:0] irq_int,
  input  logic [NEXT-1:0] irq_ext,
  output logic            osc_en,
  output logic            cpu_clk_en,
  output logic [NPER-1:0] per_clk_en,
  output logic [1:0]      mode,
  output logic [1:0]      wake_cause
);
  logic [1:0] rs_q;
  logic       rst_core_n;
  pmc_mode_e  mode_w;
  pmc_cause_e cause_w;
  logic       osc_run, in_halt, cpu_tick, per_tick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  pmc_fsm #(.STW(STW)) u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .sleep_req(sleep_req), .sleep_stby(sleep_stby), .stab_load(stab_load),
    .int_any(|irq_int), .ext_any(|irq_ext),
    .mode_o(mode_w), .cause_o(cause_w)
  );

  assign osc_run = (mode_w == M_RUN) || (mode_w == M_HALT);
  assign in_halt = (mode_w == M_HALT);

  pmc_div #(.NSTEP(CPU_STEPS), .SW(CSW)) u_cpu_div (
    .clk(clk), .rst_n(rst_core_n), .run(osc_run), .sel_in(freq_sel), .tick(cpu_tick)
  );
  pmc_div #(.NSTEP(PER_STEPS), .SW(PSW)) u_per_div (
    .clk(clk), .rst_n(rst_core_n), .run(osc_run), .sel_in(pdiv_sel), .tick(per_tick)
  );

  assign osc_en     = (mode_w != M_STBY);
  assign cpu_clk_en = cpu_tick && (mode_w == M_RUN);

  generate
    for (genvar i = 0; i < NPER; i++) begin : g_per
      assign per_clk_en[i] = per_tick && per_en[i] && !(in_halt && halt_gate[i]);
    end
  endgenerate

  assign mode       = mode_w;
  assign wake_cause = cause_w;

  p_no_pulse_osc_off_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !osc_en |-> (!cpu_clk_en && per_clk_en == '0));
  p_halt_keeps_osc_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode == 2'd1) |-> (osc_en && !cpu_clk_en));
endmodule

// File: tb/pmc_top_tb_top.sv
`timescale 1ns/1ps
module pmc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0, sleep_stby = 1'b0;
  logic [2:0]  freq_sel = '0;
  logic [1:0]  pdiv_sel = '0;
  logic [3:0]  per_en = '0, halt_gate = '0;
  logic [11:0] stab_load = '0;
  logic [3:0]  irq_int = '0;
  logic [1:0]  irq_ext = '0;
  logic        osc_en, cpu_clk_en;
  logic [3:0]  per_clk_en;
  logic [1:0]  mode, wake_cause;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmc_top dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_stby(sleep_stby),
    .freq_sel(freq_sel), .pdiv_sel(pdiv_sel), .per_en(per_en), .halt_gate(halt_gate),
    .stab_load(stab_load), .irq_int(irq_int), .irq_ext(irq_ext),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .mode(mode), .wake_cause(wake_cause)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_mode, m_cause, m_lat, m_scnt, m_ccnt, m_csel, m_pcnt, m_psel, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cause = 0; m_lat = 0; m_scnt = 0;
      m_ccnt = 0; m_csel = 0; m_pcnt = 0; m_psel = 0; m_rel = 0;
    end else begin
      if (m_rel >= 2) begin
        bit on;
        int want_c;
        on = (m_mode == 0) || (m_mode == 1);
        want_c = (freq_sel > 5) ? 5 : int'(freq_sel);
        if (!on || m_ccnt == (1 << m_csel) - 1) begin m_ccnt = 0; m_csel = want_c; end
        else m_ccnt++;
        if (!on || m_pcnt == (1 << m_psel) - 1) begin m_pcnt = 0; m_psel = int'(pdiv_sel); end
        else m_pcnt++;
        case (m_mode)
          0: if (sleep_req) begin
               if (!sleep_stby) begin
                 if (irq_int == 0 && irq_ext == 0) m_mode = 1;
               end else if (irq_ext == 0) begin
                 m_mode = 2; m_lat = int'(stab_load);
               end
             end
          1: if (irq_int != 0 || irq_ext != 0) begin
               m_mode = 0; m_cause = (irq_ext != 0) ? 2 : 1;
             end
          2: if (irq_ext != 0) begin m_mode = 3; m_scnt = m_lat; m_cause = 2; end
          default: if (m_scnt == 0) m_mode = 0; else m_scnt--;
        endcase
      end
      if (m_rel < 2) m_rel++;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_rel >= 2) begin
      bit on, ptick;
      int exp_per;
      on = (m_mode == 0) || (m_mode == 1);
      ptick = on && (m_pcnt == (1 << m_psel) - 1);
      exp_per = 0;
      for (int i = 0; i < 4; i++)
        if (ptick && per_en[i] && !(m_mode == 1 && halt_gate[i])) exp_per |= (1 << i);
      check("R9 mode", int'(mode), m_mode);
      check("R9 wake_cause", int'(wake_cause), m_cause);
      check("R1 osc_en", int'(osc_en), (m_mode != 2) ? 1 : 0);
      check("R6 cpu_clk_en", int'(cpu_clk_en),
            (m_mode == 0 && m_ccnt == (1 << m_csel) - 1) ? 1 : 0);
      check("R8 per_clk_en", int'(per_clk_en), exp_per);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic count_cpu(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (cpu_clk_en) c++; end
    step(1);
  endtask

  task automatic request(input bit stby);
    sleep_stby = stby; sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int c, c0, c1;
    @(negedge clk);
    check("R9 reset mode", int'(mode), 0);
    check("R9 reset cause", int'(wake_cause), 0);
    check("R1 reset osc_en", int'(osc_en), 1);
    step(2);
    rst_n = 1'b1;
    step(4);

    // R6: every rate, including the clamped codes
    for (int k = 0; k < 8; k++) begin
      freq_sel = 3'(k);
      step(40);
      count_cpu(64, c);
      check($sformatf("R6 pulses for code %0d", k), c, 64 >> ((k > 5) ? 5 : k));
    end

    // R7: from the slowest rate, switch to the fastest mid-period
    freq_sel = 3'd5;
    step(40);
    @(negedge clk);
    while (!cpu_clk_en) @(negedge clk);
    step(3);
    freq_sel = 3'd0;
    count_cpu(10, c);
    check("R7 no early pulse after rate change", c, 0);
    step(30);
    count_cpu(8, c);
    check("R7 new rate after boundary", c, 8);

    // R8: peripheral divider and mask, independent of the cpu rate
    freq_sel = 3'd3; pdiv_sel = 2'd2; per_en = 4'b0101;
    step(20);
    c0 = 0; c1 = 0;
    repeat (64) begin @(negedge clk); if (per_clk_en[0]) c0++; if (per_clk_en[1]) c1++; end
    step(1);
    check("R8 enabled peripheral pulses", c0, 16);
    check("R8 masked peripheral silent", c1, 0);

    // R4/R5: halt with one peripheral gated, woken by an internal line
    per_en = 4'b0011; halt_gate = 4'b0001;
    request(1'b0);
    @(negedge clk);
    check("R4 in halt", int'(mode), 1);
    c = 0; c0 = 0; c1 = 0;
    repeat (16) begin
      @(negedge clk);
      if (cpu_clk_en) c++;
      if (per_clk_en[0]) c0++;
      if (per_clk_en[1]) c1++;
      if (!osc_en) c += 100;
    end
    check("R4 cpu stopped, osc on", c, 0);
    check("R4 gated peripheral", c0, 0);
    check("R4 ungated peripheral runs", c1, 4);
    step(1);
    irq_int = 4'b0100;
    step(1);
    irq_int = '0;
    @(negedge clk);
    check("R5 halt left next clock", int'(mode), 0);
    check("R9 internal cause", int'(wake_cause), 1);

    // R10: refusals
    step(5);
    irq_int = 4'b0001;
    request(1'b0);
    @(negedge clk);
    check("R10 halt refused with pending irq", int'(mode), 0);
    step(1);
    irq_int = '0; irq_ext = 2'b01;
    request(1'b1);
    @(negedge clk);
    check("R10 standby refused with external pending", int'(mode), 0);
    step(1);
    irq_ext = '0;

    // R1/R2/R3: standby, internal ignored, settling length from captured value
    step(5);
    irq_int = 4'b1000; stab_load = 12'd20;
    request(1'b1);
    stab_load = 12'd50;
    c = 0;
    repeat (40) begin
      @(negedge clk);
      if (mode != 2'd2) c++;
      if (osc_en || cpu_clk_en || per_clk_en != 0) c += 100;
    end
    check("R2 internal irq ignored in standby", c % 100, 0);
    check("R1 all clocks off in standby", c / 100, 0);
    step(1);
    irq_int = '0; irq_ext = 2'b10;
    step(1);
    irq_ext = '0;
    c = 0; c0 = 0;
    @(negedge clk);
    while (mode == 2'd3 && c < 500) begin
      c++;
      if (cpu_clk_en || per_clk_en != 0) c0++;
      @(negedge clk);
    end
    check("R3 settling length", c, 21);
    check("R3 clocks gated while settling", c0, 0);
    check("R9 external cause", int'(wake_cause), 2);
    step(1);

    // R9: both kinds wake halt, external wins
    request(1'b0);
    irq_int = 4'b0010; irq_ext = 2'b01;
    step(1);
    irq_int = '0; irq_ext = '0;
    @(negedge clk);
    check("R9 priority external", int'(wake_cause), 2);
    check("R5 back in run", int'(mode), 0);
    step(10);
    finish_run();
  end
endmodule